// File: doc/BRIEF.md
# Temperature-Tracking Performance Level Governor

This block chooses, once per scheduling period, which of a small set of discrete voltage/frequency levels the processor runs at. The aim is to keep die temperature oscillating around an energy-optimal setpoint rather than only reacting at a thermal emergency. It does this by toggling between two neighbouring levels. The faster of the two settles above the setpoint and the slower one settles below it. A separate escape path jumps to the fastest level that an external estimator predicts will stay at or under the emergency limit.

A configuration strobe loads the faster bracketing level and the cooling setting. The slower bracketing level is always the next index up. The cooling setting is then held unchanged until the next configuration, so the governor only ever moves the performance level. A period-boundary tick comes from outside; with a 40 ms period this is one pulse every 40 ms. On each tick the block samples three inputs: the die temperature, the per-level predicted peak temperatures for the next period, and the programmed thresholds. The new level appears on the output in the following cycle, together with a one-cycle change strobe.

Top module: `thermal_level_governor`

## Requirements
- R1: Synchronous active-low reset sets the level to the default faster bracketing level (parameter, default 1), sets the cooling output to its default (parameter, default 8'h40), and clears both the change strobe and the alarm flag.
- R2: A cycle with `cfg_load` high latches `cfg_cool`. It also latches `cfg_fast_lvl`, clamped to at most NUM_LEVELS-2, as the faster bracketing level. The slower bracketing level is the faster one plus 1. On the next cycle the level output equals the faster level and the change strobe stays low. `cfg_load` takes precedence over a tick in the same cycle.
- R3: `cool_out` changes only in the cycle after a `cfg_load`. Ticks never alter it.
- R4: The level output changes only in the cycle after a cycle with `period_tick` or `cfg_load` high. Predictions presented without a tick have no effect.
- R5: After reset or configuration, the step checks are not applied and the faster bracketing level is held. This lasts until a tick on which the die temperature is strictly above the setpoint; from that tick on, including that tick, the step checks apply. The emergency check applies at all times.
- R6: Step-down applies when the prediction at the current level is strictly above the setpoint and the prediction at the slower bracketing level is strictly below it. The level then moves to the slower bracketing level.
- R7: Emergency: if the prediction at the current level is strictly above the limit, the level becomes the lowest index whose prediction is at or below the limit. This check has priority over steps R6 and R9.
- R8: If no level's prediction is at or below the limit during an emergency, the level becomes NUM_LEVELS-1 and the alarm flag is set. The flag stays set until reset; configuration does not clear it.
- R9: Step-up applies when the predictions at both the current level and the slower bracketing level are strictly below the setpoint. The level then returns to the faster bracketing level. Step-down is checked before step-up.
- R10: On a tick where no check applies, the level is kept.
- R11: `lvl_chg` is high for exactly the one cycle after a tick whose decision changed the level, and low otherwise.
- R12: Temperatures are unsigned with two fractional bits (LSB = 0.25 °C) and TEMP_W defaults to 10. A limit of 95 °C (380) and a setpoint of 68 °C (272) are therefore representable. Level 0 is the fastest level. The prediction for level i occupies bits [i*TEMP_W +: TEMP_W] of `pred_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration strobe |
| cfg_fast_lvl | input | LVL_W | Faster bracketing level index |
| cfg_cool | input | COOL_W | Cooling setting to hold |
| setpoint | input | TEMP_W | Energy-optimal target temperature |
| limit | input | TEMP_W | Emergency temperature limit |
| period_tick | input | 1 | Period-boundary pulse |
| die_temp | input | TEMP_W | Current die temperature |
| pred_bus | input | NUM_LEVELS*TEMP_W | Predicted next-period peak temperature per level |
| lvl_out | output | LVL_W | Selected performance level, 0 fastest |
| cool_out | output | COOL_W | Held cooling setting |
| lvl_chg | output | 1 | One-cycle strobe on a level change |
| alarm | output | 1 | Sticky flag: no level met the limit |

## Verification
The assertions check four properties on every cycle. The cooling output and the level move only after a configuration or a tick. The change strobe agrees with an actual level change. The alarm, once raised, stays raised. And after an emergency decision, the chosen level's prediction really is within the limit unless the alarm is raised. The priority order among the checks, the start-up hold before the first over-setpoint tick, the clamp of the bracketing level, and the exact levels chosen for given predictions can only be shown by the bench's tick sequences.

// File: rtl/gov_pkg.sv
// Shared types for the level governor.
// Assumes: nothing beyond the standard library.
package gov_pkg;
    // Which rule produced the per-tick decision
    typedef enum logic [1:0] {
        DEC_HOLD  = 2'd0,
        DEC_EMERG = 2'd1,
        DEC_DOWN  = 2'd2,
        DEC_UP    = 2'd3
    } gov_dec_e;
endpackage

// File: rtl/gov_bracket_cfg.sv
// Holds the configured bracketing level pair and the cooling setting.
// Assumes NUM_LEVELS >= 2; the faster level is clamped so the slower one exists.
module gov_bracket_cfg #(
    parameter int NUM_LEVELS = 4,
    parameter int LVL_W      = 2,
    parameter int COOL_W     = 8,
    parameter int DEF_FAST   = 1,
    parameter int DEF_COOL   = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [LVL_W-1:0]  cfg_fast_lvl,
    input  logic [COOL_W-1:0] cfg_cool,
    output logic [LVL_W-1:0]  fast_new,
    output logic [LVL_W-1:0]  fast_lvl,
    output logic [LVL_W-1:0]  slow_lvl,
    output logic [COOL_W-1:0] cool_q
);
    localparam logic [LVL_W-1:0] MAX_FAST = LVL_W'(NUM_LEVELS - 2);

    // Clamp the requested faster level so its slower neighbour is valid
    always_comb begin
        fast_new = (cfg_fast_lvl > MAX_FAST) ? MAX_FAST : cfg_fast_lvl;
    end

    // Latch bracket and cooling setting on configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_lvl <= LVL_W'(DEF_FAST);
            cool_q   <= COOL_W'(DEF_COOL);
        end else if (cfg_load) begin
            fast_lvl <= fast_new;
            cool_q   <= cfg_cool;
        end
    end

    // Slower bracketing level is always the next index
    always_comb begin
        slow_lvl = fast_lvl + LVL_W'(1);
    end
endmodule

// File: rtl/gov_safe_scan.sv
// Finds the fastest level whose predicted peak is at or below the limit.
// Assumes predictions are packed with level i at bits [i*TEMP_W +: TEMP_W].
module gov_safe_scan #(
    parameter int NUM_LEVELS = 4,
    parameter int TEMP_W     = 10,
    parameter int LVL_W      = 2
) (
    input  logic [NUM_LEVELS*TEMP_W-1:0] pred_bus,
    input  logic [TEMP_W-1:0]            limit,
    output logic [LVL_W-1:0]             safe_lvl,
    output logic                         none_safe
);
    logic [NUM_LEVELS-1:0] ok;

    // One comparator per level
    genvar g;
    generate
        for (g = 0; g < NUM_LEVELS; g++) begin : g_cmp
            assign ok[g] = (pred_bus[g*TEMP_W +: TEMP_W] <= limit);
        end
    endgenerate

    // Lowest safe index wins; slowest level if none is safe
    always_comb begin
        safe_lvl  = LVL_W'(NUM_LEVELS - 1);
        none_safe = ~|ok;
        for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
            if (ok[i]) safe_lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/gov_decide.sv
// Per-tick decision: emergency first, then step-down, then step-up, else hold.
// Assumes slow_lvl < NUM_LEVELS and cur_lvl < NUM_LEVELS.
module gov_decide
    import gov_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int TEMP_W     = 10,
    parameter int LVL_W      = 2
) (
    input  logic [NUM_LEVELS*TEMP_W-1:0] pred_bus,
    input  logic [LVL_W-1:0]             cur_lvl,
    input  logic [LVL_W-1:0]             fast_lvl,
    input  logic [LVL_W-1:0]             slow_lvl,
    input  logic [TEMP_W-1:0]            setpoint,
    input  logic [TEMP_W-1:0]            limit,
    input  logic                         track_en,
    input  logic [LVL_W-1:0]             safe_lvl,
    input  logic                         none_safe,
    output logic [LVL_W-1:0]             next_lvl,
    output gov_dec_e                     dec,
    output logic                         raise_alarm
);
    logic [TEMP_W-1:0] p_cur;
    logic [TEMP_W-1:0] p_slow;

    // Pick predictions for the current and slower bracketing levels
    always_comb begin
        p_cur  = pred_bus[int'(cur_lvl)  * TEMP_W +: TEMP_W];
        p_slow = pred_bus[int'(slow_lvl) * TEMP_W +: TEMP_W];
    end

    // Priority decision
    always_comb begin
        next_lvl    = cur_lvl;
        dec         = DEC_HOLD;
        raise_alarm = 1'b0;
        if (p_cur > limit) begin
            dec         = DEC_EMERG;
            next_lvl    = safe_lvl;
            raise_alarm = none_safe;
        end else if (track_en && (p_cur > setpoint) && (p_slow < setpoint)) begin
            dec      = DEC_DOWN;
            next_lvl = slow_lvl;
        end else if (track_en && (p_cur < setpoint) && (p_slow < setpoint)) begin
            dec      = DEC_UP;
            next_lvl = fast_lvl;
        end
    end
endmodule

// File: rtl/thermal_level_governor.sv
// Top of the governor: holds the level, tracking-enable, strobe and alarm.
// Assumes period_tick is a single-cycle pulse from an external period timer
// and that predictions are valid in the tick cycle.
module thermal_level_governor
    import gov_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int TEMP_W     = 10,
    parameter int COOL_W     = 8,
    parameter int DEF_FAST   = 1,
    parameter int DEF_COOL   = 8'h40,
    localparam int LVL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_load,
    input  logic [LVL_W-1:0]             cfg_fast_lvl,
    input  logic [COOL_W-1:0]            cfg_cool,
    input  logic [TEMP_W-1:0]            setpoint,
    input  logic [TEMP_W-1:0]            limit,
    input  logic                         period_tick,
    input  logic [TEMP_W-1:0]            die_temp,
    input  logic [NUM_LEVELS*TEMP_W-1:0] pred_bus,
    output logic [LVL_W-1:0]             lvl_out,
    output logic [COOL_W-1:0]            cool_out,
    output logic                         lvl_chg,
    output logic                         alarm
);
    logic [LVL_W-1:0] fast_new, fast_lvl, slow_lvl;
    logic [LVL_W-1:0] safe_lvl, next_lvl;
    logic             none_safe, raise_alarm;
    logic             armed_q, track_en;
    logic [LVL_W-1:0] lvl_q;
    logic             chg_q, alarm_q;
    gov_dec_e         dec;

    gov_bracket_cfg #(
        .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .COOL_W(COOL_W),
        .DEF_FAST(DEF_FAST), .DEF_COOL(DEF_COOL)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_fast_lvl(cfg_fast_lvl), .cfg_cool(cfg_cool),
        .fast_new(fast_new), .fast_lvl(fast_lvl), .slow_lvl(slow_lvl),
        .cool_q(cool_out)
    );

    gov_safe_scan #(
        .NUM_LEVELS(NUM_LEVELS), .TEMP_W(TEMP_W), .LVL_W(LVL_W)
    ) u_scan (
        .pred_bus(pred_bus), .limit(limit),
        .safe_lvl(safe_lvl), .none_safe(none_safe)
    );

    // Tracking starts on the first tick that sees the die above setpoint
    always_comb begin
        track_en = armed_q | (die_temp > setpoint);
    end

    gov_decide #(
        .NUM_LEVELS(NUM_LEVELS), .TEMP_W(TEMP_W), .LVL_W(LVL_W)
    ) u_dec (
        .pred_bus(pred_bus), .cur_lvl(lvl_q), .fast_lvl(fast_lvl),
        .slow_lvl(slow_lvl), .setpoint(setpoint), .limit(limit),
        .track_en(track_en), .safe_lvl(safe_lvl), .none_safe(none_safe),
        .next_lvl(next_lvl), .dec(dec), .raise_alarm(raise_alarm)
    );

    // Level, tracking state, strobe and sticky alarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= LVL_W'(DEF_FAST);
            armed_q <= 1'b0;
            chg_q   <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            chg_q <= 1'b0;
            if (cfg_load) begin
                lvl_q   <= fast_new;
                armed_q <= 1'b0;
            end else if (period_tick) begin
                lvl_q   <= next_lvl;
                chg_q   <= (next_lvl != lvl_q);
                armed_q <= track_en;
                if (raise_alarm) alarm_q <= 1'b1;
            end
        end
    end

    assign lvl_out = lvl_q;
    assign lvl_chg = chg_q;
    assign alarm   = alarm_q;
endmodule

// File: rtl/gov_checker.sv
// Temporal checks on the governor's ports, bound to every instance.
// Assumes reset is held for at least two cycles at start.
module gov_checker #(
    parameter int NUM_LEVELS = 4,
    parameter int TEMP_W     = 10,
    parameter int COOL_W     = 8,
    parameter int LVL_W      = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_load,
    input logic                         period_tick,
    input logic [TEMP_W-1:0]            limit,
    input logic [NUM_LEVELS*TEMP_W-1:0] pred_bus,
    input logic [LVL_W-1:0]             lvl_out,
    input logic [COOL_W-1:0]            cool_out,
    input logic                         lvl_chg,
    input logic                         alarm
);
    logic [NUM_LEVELS*TEMP_W-1:0] pred_q;
    logic [TEMP_W-1:0]            lim_q;

    // Previous-cycle predictions and limit for the emergency check
    always_ff @(posedge clk) begin
        pred_q <= pred_bus;
        lim_q  <= limit;
    end

    // R3: cooling setting moves only after configuration
    p_cool_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cool_out));

    // R4: level moves only after a tick or configuration
    p_level_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_tick && !cfg_load) |=> $stable(lvl_out));

    // R11: strobe agrees with a real level change after a tick
    p_strobe_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !cfg_load) |=> (lvl_chg == (lvl_out != $past(lvl_out))));

    // R11: no strobe without a tick
    p_strobe_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !period_tick |=> !lvl_chg);

    // R8: alarm is sticky
    p_alarm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    // R7: emergency decision lands on a level within the limit, or raises alarm
    p_emerg_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !cfg_load &&
         (pred_bus[int'(lvl_out)*TEMP_W +: TEMP_W] > limit))
        |=> (alarm || (pred_q[int'(lvl_out)*TEMP_W +: TEMP_W] <= lim_q)));
endmodule

bind thermal_level_governor gov_checker #(
    .NUM_LEVELS(NUM_LEVELS), .TEMP_W(TEMP_W), .COOL_W(COOL_W), .LVL_W(LVL_W)
) u_gov_checker (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .period_tick(period_tick),
    .limit(limit), .pred_bus(pred_bus), .lvl_out(lvl_out),
    .cool_out(cool_out), .lvl_chg(lvl_chg), .alarm(alarm)
);

// File: tb/thermal_level_governor_bench.sv
module thermal_level_governor_bench;
    localparam int NL = 4;
    localparam int TW = 10;
    localparam int CW = 8;
    localparam int LW = 2;
    localparam logic [TW-1:0] SP  = 10'd272; // R12: 68 C in quarter degrees
    localparam logic [TW-1:0] LIM = 10'd380; // R12: 95 C

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 1'b0;
    logic [LW-1:0] cfg_fast_lvl = '0;
    logic [CW-1:0] cfg_cool = '0;
    logic [TW-1:0] setpoint = SP;
    logic [TW-1:0] limit = LIM;
    logic period_tick = 1'b0;
    logic [TW-1:0] die_temp = '0;
    logic [NL*TW-1:0] pred_bus = '0;
    logic [LW-1:0] lvl_out;
    logic [CW-1:0] cool_out;
    logic lvl_chg, alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    thermal_level_governor #(.NUM_LEVELS(NL), .TEMP_W(TW), .COOL_W(CW))
    u_thermal_level_governor (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_fast_lvl(cfg_fast_lvl), .cfg_cool(cfg_cool),
        .setpoint(setpoint), .limit(limit), .period_tick(period_tick),
        .die_temp(die_temp), .pred_bus(pred_bus), .lvl_out(lvl_out),
        .cool_out(cool_out), .lvl_chg(lvl_chg), .alarm(alarm)
    );

    typedef struct packed {
        logic [TW-1:0] die;
        logic [TW-1:0] p0, p1, p2, p3;
        logic [LW-1:0] lvl;
        logic          chg;
        logic          alm;
    } vec_t;

    // Bracket fast=1, slow=2, setpoint 272, limit 380
    localparam vec_t VECS [11] = '{
        '{10'd260, 10'd300, 10'd290, 10'd260, 10'd240, 2'd1, 1'b0, 1'b0}, // R5 hold before arming
        '{10'd280, 10'd300, 10'd290, 10'd260, 10'd240, 2'd2, 1'b1, 1'b0}, // R6 step-down
        '{10'd275, 10'd300, 10'd290, 10'd265, 10'd240, 2'd1, 1'b1, 1'b0}, // R9 step-up
        '{10'd275, 10'd300, 10'd272, 10'd260, 10'd240, 2'd1, 1'b0, 1'b0}, // R10 equal to setpoint
        '{10'd275, 10'd420, 10'd400, 10'd370, 10'd300, 2'd2, 1'b1, 1'b0}, // R7 emergency
        '{10'd275, 10'd300, 10'd290, 10'd380, 10'd300, 2'd2, 1'b0, 1'b0}, // R10 at limit
        '{10'd275, 10'd330, 10'd350, 10'd390, 10'd300, 2'd0, 1'b1, 1'b0}, // R7 fastest safe
        '{10'd275, 10'd300, 10'd290, 10'd250, 10'd240, 2'd2, 1'b1, 1'b0}, // R6 from level 0
        '{10'd275, 10'd400, 10'd400, 10'd400, 10'd400, 2'd3, 1'b1, 1'b1}, // R8 none safe
        '{10'd275, 10'd300, 10'd290, 10'd250, 10'd250, 2'd1, 1'b1, 1'b1}, // R9 back to fast
        '{10'd275, 10'd300, 10'd250, 10'd280, 10'd240, 2'd1, 1'b0, 1'b1}  // R10 slow above
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one period tick; return at the negedge after the decision edge
    task automatic tick(input logic [TW-1:0] d, input logic [TW-1:0] a0,
                        input logic [TW-1:0] a1, input logic [TW-1:0] a2,
                        input logic [TW-1:0] a3);
        @(negedge clk);
        die_temp    = d;
        pred_bus    = {a3, a2, a1, a0};
        period_tick = 1'b1;
        @(negedge clk);
        period_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 lvl", lvl_out, 1);
        chk("R1 cool", cool_out, 8'h40);
        chk("R1 chg", lvl_chg, 0);
        chk("R1 alarm", alarm, 0);
        rst_n = 1'b1;

        // R2: configure fast=1, cooling 5A
        @(negedge clk);
        cfg_fast_lvl = 2'd1; cfg_cool = 8'h5A; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R2 lvl", lvl_out, 1);
        chk("R2 cool", cool_out, 8'h5A);
        chk("R2 chg", lvl_chg, 0);

        // Table walk
        for (int i = 0; i < 11; i++) begin
            tick(VECS[i].die, VECS[i].p0, VECS[i].p1, VECS[i].p2, VECS[i].p3);
            chk($sformatf("vec%0d lvl", i), lvl_out, VECS[i].lvl);
            chk($sformatf("vec%0d R11 chg", i), lvl_chg, VECS[i].chg);
            chk($sformatf("vec%0d R8 alarm", i), alarm, VECS[i].alm);
            @(negedge clk);
            chk($sformatf("vec%0d R11 pulse end", i), lvl_chg, 0);
        end
        chk("R3 cool after ticks", cool_out, 8'h5A);

        // R4: emergency-looking predictions without a tick change nothing
        die_temp = 10'd300;
        pred_bus = {10'd400, 10'd400, 10'd400, 10'd200};
        repeat (3) @(negedge clk);
        chk("R4 no tick lvl", lvl_out, 1);
        chk("R4 no tick chg", lvl_chg, 0);

        // R2: configuration wins over a simultaneous tick
        cfg_fast_lvl = 2'd0; cfg_cool = 8'h11; cfg_load = 1'b1; period_tick = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; period_tick = 1'b0;
        chk("R2 cfg over tick lvl", lvl_out, 0);
        chk("R2 cfg over tick chg", lvl_chg, 0);
        chk("R8 alarm kept over cfg", alarm, 1);

        // R1 R8: reset clears alarm
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 alarm cleared", alarm, 0);
        chk("R1 cool default", cool_out, 8'h40);
        chk("R1 lvl default", lvl_out, 1);
        rst_n = 1'b1;

        // R2: clamp requested level 3 to 2, slower becomes 3
        @(negedge clk);
        cfg_fast_lvl = 2'd3; cfg_cool = 8'h33; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R2 clamp lvl", lvl_out, 2);
        chk("R3 cool new", cool_out, 8'h33);
        // R5: not yet armed, step-down conditions ignored
        tick(10'd250, 10'd300, 10'd300, 10'd300, 10'd250);
        chk("R5 unarmed hold", lvl_out, 2);
        // R5 arming tick applies the step immediately
        tick(10'd280, 10'd300, 10'd300, 10'd300, 10'd250);
        chk("R6 clamp slow", lvl_out, 3);
        // R5 stays armed even with die below setpoint
        tick(10'd250, 10'd300, 10'd300, 10'd250, 10'd250);
        chk("R9 armed step-up", lvl_out, 2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule